// File: doc/BRIEF.md
# Three-Wire Serial Register and Scratchpad Slave

This block is the host-facing serial port of a timekeeping device. A host uses three wires to read and write a small set of clock/calendar registers and a 31-byte scratchpad RAM: an enable line, a serial clock and one data line that is bidirectional. The timekeeping counters are outside this block. It reaches them through a plain register port: a write strobe with address and data, and a read-data input that follows the presented address.

Each transaction begins when the enable line rises. The first eight clocks carry a command byte, least significant bit first. That byte picks the direction, the target space and an address. Bits are captured on rising serial-clock edges and launched on falling edges. The whole interface is oversampled in the fast system clock domain, so all three inputs pass through synchronizers before any edge is detected. The data line is returned as a driven value plus an output enable, and the pad tristate lives outside the block. Address 31 turns the transfer into a burst that starts at address 0 and walks the selected space.

Top module: `tws_slave`

## Requirements
- R1: While the synchronized enable is low the block is idle, `sdOe` is low and any partial transfer is dropped. A new command starts when enable rises. `sdOe` is low after reset.
- R2: The command byte arrives LSB first. Bit 0 = 1 means read and 0 means write. Bits 5..1 are the address. Bit 6 selects the clock registers (0) or the RAM (1).
- R3: Write data arrives LSB first on rising SCLK edges. A byte is committed only after its 8th bit, so a byte cut short by enable going low leaves its target unchanged.
- R4: In a non-burst write, every clock after the eight data bits is ignored. No other byte is changed.
- R5: In a read, bit 0 of the data is driven on the falling edge right after the rising edge that captured command bit 7. Each later falling edge drives the next bit, LSB first.
- R6: During a read, `sdOe` goes low on every rising SCLK edge and goes high again on the next falling edge. `sdOe` is never high outside a read.
- R7: In a non-burst read, extra clocks send the same byte again for as long as enable stays high.
- R8: Address 31 selects burst. The burst starts at address 0 and steps by one per byte. RAM wraps after address 30 and the clock registers wrap after address 7, for both reads and writes.
- R9: A clock-space write to address 0..7 gives exactly one `regWrEn` pulse carrying `regAddr` and `regWrData`. Clock-space addresses 8..30 read as 0 and produce no strobe.
- R10: A write command whose bit 7 is 0 changes nothing: no RAM byte and no register strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rstN | input | 1 | Active-low synchronous reset |
| ceIn | input | 1 | Transaction enable from host (asynchronous) |
| sclkIn | input | 1 | Serial clock from host (asynchronous) |
| sdIn | input | 1 | Serial data from the pad |
| sdOut | output | 1 | Serial data to drive onto the pad |
| sdOe | output | 1 | Pad output enable for sdOut |
| regAddr | output | 3 | Clock register address |
| regWrEn | output | 1 | One-cycle clock register write strobe |
| regWrData | output | 8 | Clock register write data |
| regRdData | input | 8 | Read data for the register at regAddr |

## Verification
The bench goes after the first read bit. A design that waited one more falling edge would return every byte shifted by one bit. It cuts writes off partway through a byte. A design that committed bit by bit would corrupt the target. It adds extra clocks after single-byte writes and reads. A wrong design would spill into the next address, or would walk forward instead of repeating the byte. Long bursts cross the wrap point of each space, where a wrong limit reads a missing byte or skips address 0. Disabled writes and clock addresses above 7 must leave both the RAM and the register strobe untouched.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_DONE
  } twsState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic cmdShift;
    logic addrLoad;
    logic wrShift;
    logic commit;
    logic addrInc;
    logic outLoad;
  } twsStrobe_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BIT_W      = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceIn,
  input  logic             sclkIn,
  input  logic             sdIn,
  input  logic             cmdIsRead,
  input  logic             cmdWrEn,
  input  logic             burst,
  output logic             sdSync,
  output logic [BIT_W-1:0] bitIdx,
  output logic             sdOe,
  output twsStrobe_t       str
);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

  logic [2:0] syncOut;
  logic ceS, sclkS, sclkPrev, sclkRise, sclkFall;
  twsState_t state;
  logic [BIT_W-1:0] bitCnt;

  tws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .dIn ({ceIn, sclkIn, sdIn}),
    .dOut(syncOut)
  );

  assign ceS      = syncOut[2];
  assign sclkS    = syncOut[1];
  assign sdSync   = syncOut[0];
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign bitIdx   = bitCnt;

  always_comb begin
    str = '0;
    if (ceS) begin
      case (state)
        ST_CMD: if (sclkRise) begin
          str.cmdShift = 1'b1;
          str.addrLoad = (bitCnt == LAST);
        end
        ST_WR: if (sclkRise) begin
          str.wrShift = 1'b1;
          str.commit  = (bitCnt == LAST);
          str.addrInc = (bitCnt == LAST);
        end
        ST_RD: if (sclkFall) begin
          str.outLoad = 1'b1;
          str.addrInc = (bitCnt == LAST);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      sdOe     <= 1'b0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!ceS) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        sdOe   <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state  <= ST_CMD;
            bitCnt <= '0;
          end
          ST_CMD: if (sclkRise) begin
            bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
            if (bitCnt == LAST)
              state <= cmdIsRead ? ST_RD : (cmdWrEn ? ST_WR : ST_DONE);
          end
          ST_WR: if (sclkRise) begin
            bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
            if (bitCnt == LAST && !burst) state <= ST_DONE;
          end
          ST_RD: begin
            if (sclkRise) sdOe <= 1'b0;
            if (sclkFall) begin
              sdOe   <= 1'b1;
              bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_CE_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !ceS |=> !sdOe); // R1
  AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    sdOe |-> state == ST_RD); // R6
  AST_OE_DROP_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (ceS && state == ST_RD && sclkRise) |=> !sdOe); // R6
  AST_OE_RISE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> $past(sclkFall)); // R5
endmodule

// File: rtl/tws_dp.sv
module tws_dp
  import tws_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 31,
  parameter int CLK_REGS  = 8,
  localparam int BIT_W    = $clog2(DATA_W),
  localparam int REG_AW   = $clog2(CLK_REGS),
  localparam int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobe_t        str,
  input  logic              sdSync,
  input  logic [BIT_W-1:0]  bitIdx,
  output logic              cmdIsRead,
  output logic              cmdWrEn,
  output logic              burst,
  output logic              sdOut,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);
  localparam logic [ADDR_W-1:0] BURST_ADDR = '1;
  localparam logic [ADDR_W-1:0] RAM_LAST   = ADDR_W'(RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] CLK_LAST   = ADDR_W'(CLK_REGS - 1);

  logic [DATA_W-2:0] cmdReg, wrReg;
  logic [DATA_W-1:0] cmdNext, wrNext, rdByte;
  logic [ADDR_W-1:0] addr, addrLimit;
  logic              spaceRam, clkValid, ramValid;
  logic [DATA_W-1:0] ram [RAM_DEPTH];

  assign cmdNext   = {sdSync, cmdReg};
  assign wrNext    = {sdSync, wrReg};
  assign cmdIsRead = cmdNext[0];
  assign cmdWrEn   = cmdNext[7];
  assign addrLimit = spaceRam ? RAM_LAST : CLK_LAST;
  assign clkValid  = (addr <= CLK_LAST);
  assign ramValid  = (addr <= RAM_LAST);
  assign rdByte    = spaceRam ? (ramValid ? ram[addr] : '0)
                              : (clkValid ? regRdData : '0);
  assign regAddr   = addr[REG_AW-1:0];
  assign regWrData = wrNext;
  assign regWrEn   = str.commit && !spaceRam && clkValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      wrReg    <= '0;
      addr     <= '0;
      spaceRam <= 1'b0;
      burst    <= 1'b0;
      sdOut    <= 1'b0;
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
    end else begin
      if (str.cmdShift) cmdReg <= cmdNext[DATA_W-1:1];
      if (str.wrShift)  wrReg  <= wrNext[DATA_W-1:1];
      if (str.addrLoad) begin
        spaceRam <= cmdNext[6];
        burst    <= (cmdNext[5:1] == BURST_ADDR);
        addr     <= (cmdNext[5:1] == BURST_ADDR) ? '0 : cmdNext[5:1];
      end else if (str.addrInc && burst) begin
        addr <= (addr == addrLimit) ? '0 : addr + 1'b1;
      end
      if (str.commit && spaceRam && ramValid) ram[addr] <= wrNext;
      if (str.outLoad) sdOut <= rdByte[bitIdx];
    end
  end

  AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |-> cmdReg[DATA_W-2]); // R10
  AST_BURST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    burst |-> addr <= addrLimit); // R8
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RAM_DEPTH   = 31,
  parameter int CLK_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ceIn,
  input  logic                        sclkIn,
  input  logic                        sdIn,
  output logic                        sdOut,
  output logic                        sdOe,
  output logic [$clog2(CLK_REGS)-1:0] regAddr,
  output logic                        regWrEn,
  output logic [DATA_W-1:0]           regWrData,
  input  logic [DATA_W-1:0]           regRdData
);
  localparam int BIT_W = $clog2(DATA_W);

  twsStrobe_t       str;
  logic             sdSync, cmdIsRead, cmdWrEn, burst;
  logic [BIT_W-1:0] bitIdx;

  tws_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ceIn     (ceIn),
    .sclkIn   (sclkIn),
    .sdIn     (sdIn),
    .cmdIsRead(cmdIsRead),
    .cmdWrEn  (cmdWrEn),
    .burst    (burst),
    .sdSync   (sdSync),
    .bitIdx   (bitIdx),
    .sdOe     (sdOe),
    .str      (str)
  );

  tws_dp #(.DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH), .CLK_REGS(CLK_REGS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .sdSync   (sdSync),
    .bitIdx   (bitIdx),
    .cmdIsRead(cmdIsRead),
    .cmdWrEn  (cmdWrEn),
    .burst    (burst),
    .sdOut    (sdOut),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData)
  );
endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN, ceIn, sclkIn, sdIn;
  logic       sdOut, sdOe, regWrEn;
  logic [2:0] regAddr;
  logic [7:0] regWrData, regRdData;

  logic [7:0] regFile [8];
  logic [7:0] expRam [31];
  logic [7:0] expReg [8];
  logic [7:0] rdBuf [40];
  logic [7:0] wrBuf [40];
  int total = 0, bad = 0, oeErr = 0, wrPulses = 0;

  always #10 clk = ~clk;

  tws_slave dut (
    .clk(clk), .rstN(rstN), .ceIn(ceIn), .sclkIn(sclkIn), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  // stand-in for the timekeeping registers
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) regFile[i] <= 8'h00;
    end else if (regWrEn) begin
      regFile[regAddr] <= regWrData;
      wrPulses <= wrPulses + 1;
    end
  end
  assign regRdData = regFile[regAddr];

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mkCmd(bit rd, bit ram, logic [4:0] a, bit we);
    return {we, ram, a, rd};
  endfunction

  task automatic sclkBit(logic b);
    sdIn = b; sclkIn = 1'b1; tick(HALF);
    sclkIn = 1'b0; tick(HALF);
  endtask

  task automatic sendByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) sclkBit(b[i]);
  endtask

  task automatic readByte(int idx);
    for (int i = 0; i < 8; i++) begin
      rdBuf[idx][i] = sdOut;
      if (sdOe !== 1'b1) oeErr++;
      sdIn = 1'b0; sclkIn = 1'b1; tick(HALF);
      if (sdOe !== 1'b0) oeErr++;
      sclkIn = 1'b0; tick(HALF);
    end
  endtask

  task automatic writeTxn(logic [7:0] cmd, int n);
    ceIn = 1'b1; tick(HALF);
    sendByte(cmd);
    for (int k = 0; k < n; k++) sendByte(wrBuf[k]);
    ceIn = 1'b0; tick(HALF);
  endtask

  task automatic readTxn(logic [7:0] cmd, int n);
    oeErr = 0;
    ceIn = 1'b1; tick(HALF);
    sendByte(cmd);
    for (int k = 0; k < n; k++) readByte(k);
    ceIn = 1'b0; tick(HALF);
    check("R6 oe toggling", oeErr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [4:0] a;
    logic [7:0] d;
    int p0;
    void'($urandom(32'h1302_abcd));
    rstN = 1'b0; ceIn = 1'b0; sclkIn = 1'b0; sdIn = 1'b0;
    for (int i = 0; i < 31; i++) expRam[i] = 8'h00;
    for (int i = 0; i < 8; i++) expReg[i] = 8'h00;
    tick(6); rstN = 1'b1; tick(6);
    check("R1 reset oe", int'(sdOe), 0);

    // random single RAM write then read (R2, R3, R5)
    for (int it = 0; it < 16; it++) begin
      a = 5'($urandom % 31); d = 8'($urandom);
      wrBuf[0] = d; writeTxn(mkCmd(0, 1, a, 1), 1); expRam[a] = d;
      readTxn(mkCmd(1, 1, a, 1), 1);
      check("R2 R3 R5 ram single", rdBuf[0], expRam[a]);
    end

    // clock register single writes (R9)
    for (int it = 0; it < 6; it++) begin
      a = 5'($urandom % 8); d = 8'($urandom);
      p0 = wrPulses;
      wrBuf[0] = d; writeTxn(mkCmd(0, 0, a, 1), 1); expReg[a] = d;
      check("R9 strobe count", wrPulses - p0, 1);
      check("R9 register value", regFile[a[2:0]], d);
      readTxn(mkCmd(1, 0, a, 1), 1);
      check("R5 clock read", rdBuf[0], expReg[a]);
    end

    // write-disable bit (R10)
    wrBuf[0] = ~expRam[5]; writeTxn(mkCmd(0, 1, 5'd5, 0), 1);
    readTxn(mkCmd(1, 1, 5'd5, 1), 1);
    check("R10 ram unchanged", rdBuf[0], expRam[5]);
    p0 = wrPulses;
    wrBuf[0] = 8'h5a; writeTxn(mkCmd(0, 0, 5'd2, 0), 1);
    check("R10 no strobe", wrPulses - p0, 0);

    // extra clocks after single write (R4)
    wrBuf[0] = 8'hc3; wrBuf[1] = ~expRam[4];
    writeTxn(mkCmd(0, 1, 5'd3, 1), 2); expRam[3] = 8'hc3;
    readTxn(mkCmd(1, 1, 5'd3, 1), 1);
    check("R4 target byte", rdBuf[0], 8'hc3);
    readTxn(mkCmd(1, 1, 5'd4, 1), 1);
    check("R4 neighbour untouched", rdBuf[0], expRam[4]);

    // extra clocks after single read (R7)
    readTxn(mkCmd(1, 1, 5'd9, 1), 3);
    check("R7 repeat 1", rdBuf[1], expRam[9]);
    check("R7 repeat 2", rdBuf[2], expRam[9]);

    // RAM burst write and read with wrap (R8)
    for (int k = 0; k < 31; k++) begin
      wrBuf[k] = 8'($urandom); expRam[k] = wrBuf[k];
    end
    writeTxn(mkCmd(0, 1, 5'd31, 1), 31);
    readTxn(mkCmd(1, 1, 5'd31, 1), 32);
    for (int k = 0; k < 32; k++) check("R8 ram burst", rdBuf[k], expRam[k % 31]);

    // clock burst (R8, R9)
    for (int k = 0; k < 8; k++) begin
      wrBuf[k] = 8'($urandom); expReg[k] = wrBuf[k];
    end
    p0 = wrPulses;
    writeTxn(mkCmd(0, 0, 5'd31, 1), 8);
    check("R9 burst strobes", wrPulses - p0, 8);
    readTxn(mkCmd(1, 0, 5'd31, 1), 9);
    for (int k = 0; k < 9; k++) check("R8 clock burst", rdBuf[k], expReg[k % 8]);

    // clock space above 7 (R9)
    readTxn(mkCmd(1, 0, 5'd12, 1), 1);
    check("R9 high clock addr reads 0", rdBuf[0], 0);
    p0 = wrPulses;
    wrBuf[0] = 8'hff; writeTxn(mkCmd(0, 0, 5'd12, 1), 1);
    check("R9 high clock addr no strobe", wrPulses - p0, 0);

    // abort mid byte (R3, R1)
    ceIn = 1'b1; tick(HALF);
    sendByte(mkCmd(0, 1, 5'd7, 1));
    for (int i = 0; i < 5; i++) sclkBit(~expRam[7][i]);
    ceIn = 1'b0; tick(HALF);
    readTxn(mkCmd(1, 1, 5'd7, 1), 1);
    check("R3 partial byte dropped", rdBuf[0], expRam[7]);
    ceIn = 1'b1; tick(HALF);
    sendByte(mkCmd(1, 1, 5'd2, 1));
    check("R1 driving before abort", int'(sdOe), 1);
    ceIn = 1'b0; tick(6);
    check("R1 released on ce low", int'(sdOe), 0);
    tick(HALF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule